// File: doc/BRIEF.md
# Shared-Term Programmable Logic Array Slice

This block is the logic core of one slice of a programmable logic device. Forty input signals enter an AND plane that can use each signal in its true or its inverted form. The plane forms 56 product terms, each selected by its own literal mask. An OR plane then builds 16 sum-of-products outputs, one per macrocell. Routing is fully shared: any product term can feed any number of sums, and no term belongs to a fixed output.

A product term can also be taken out of the OR plane and used as a control term instead. Each macrocell has four control outputs, and the slice as a whole has four more. The four kinds are, in order, clock (kind 0), clock enable (kind 1), set/reset (kind 2) and output enable (kind 3). Each control output is chosen by a term index and an enable bit. The product terms and the sums are purely combinational from the inputs. The configuration sits in registers that are written one entry per clock through an address, write-enable and data port.

Configuration addresses: 0..55 select a term row, 56..71 select the control word of macrocell 0..15, and 72 selects the block-wide control word. A term row is 97 bits wide. Bits [39:0] are the true-literal mask, bits [79:40] the complement-literal mask, bits [95:80] the sum routing (bit 80+m feeds sum m), and bit 96 is the divert flag. A control word is 28 bits wide. For kind k, bits [7k+5:7k] hold the term index and bit 7k+6 enables the output.

Top module: `pla_slice`

## Requirements
- R1: Product term t is 1 exactly when every input i whose row bit i is set is 1 and every input i whose row bit 40+i is set is 0.
- R2: A product term with no mask bits set evaluates to 1.
- R3: A product term whose mask selects both the true and the complement form of the same input evaluates to 0.
- R4: `sum_out[m]` is the OR of all product terms that have row bit 80+m set and row bit 96 clear.
- R5: A sum with no routed terms outputs 0, and one term routed to several sums drives all of them.
- R6: A term with row bit 96 set adds to no sum, but it can still be picked as a control term.
- R7: `mc_ctl[4m+k]` equals product term idx when field k of the macrocell m control word is enabled and idx is below 56. Otherwise it is 0.
- R8: `blk_ctl[k]` follows the same rule, using the control word at address 72.
- R9: A write is sampled on a rising clock edge and changes the outputs only from that edge on. With no write, the outputs depend only on `in_vec`.
- R10: Reset clears all configuration, so every sum and every control output is 0.
- R11: Writes to addresses above 72 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration |
| in_vec | input | 40 | Signals to the AND plane |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration entry address |
| cfg_wdata | input | 97 | Configuration entry data |
| sum_out | output | 16 | Sum-of-products value per macrocell |
| mc_ctl | output | 64 | Per-macrocell control terms, bit 4m+k |
| blk_ctl | output | 4 | Block-wide control terms, bit k |

## Verification
Several properties are checked on every cycle. A term whose mask has a true/complement conflict must read 0. Every control output must be 0 while its field is disabled. The outputs must be all zero on leaving reset. They must hold still whenever neither the inputs changed nor a write landed on the previous edge. The actual Boolean value of each sum and control output is shown only by the bench scenarios. These compare every output against an independent model of the configured equations: first directed rows for empty, conflicting, shared and diverted terms, then a fully random configuration driven with random inputs.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;
    localparam int N_IN     = 40;
    localparam int N_TERM   = 56;
    localparam int N_SUM    = 16;
    localparam int N_KIND   = 4;
    localparam int IDX_W    = $clog2(N_TERM);
    localparam int MASK_W   = 2 * N_IN;
    localparam int ROW_W    = MASK_W + N_SUM + 1;
    localparam int FIELD_W  = IDX_W + 1;
    localparam int CTL_W    = N_KIND * FIELD_W;
    localparam int BLK_ADDR = N_TERM + N_SUM;
    localparam int ADDR_W   = $clog2(BLK_ADDR + 1);
endpackage

// File: rtl/pla_cfg_store.sv
`timescale 1ns/1ps
module pla_cfg_store
    import pla_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [ROW_W-1:0]                  cfg_wdata,
    output logic [N_TERM-1:0][MASK_W-1:0]     masks,
    output logic [N_TERM-1:0][N_SUM-1:0]      routes,
    output logic [N_TERM-1:0]                 divert,
    output logic [N_SUM-1:0][CTL_W-1:0]       mc_words,
    output logic [CTL_W-1:0]                  blk_word
);
    logic [N_TERM-1:0][ROW_W-1:0] rows;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows     <= '0;
            mc_words <= '0;
            blk_word <= '0;
        end else if (cfg_we) begin
            for (int t = 0; t < N_TERM; t++)
                if (cfg_addr == ADDR_W'(t))
                    rows[t] <= cfg_wdata;
            for (int m = 0; m < N_SUM; m++)
                if (cfg_addr == ADDR_W'(N_TERM + m))
                    mc_words[m] <= cfg_wdata[CTL_W-1:0];
            if (cfg_addr == ADDR_W'(BLK_ADDR))
                blk_word <= cfg_wdata[CTL_W-1:0];
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_row
        assign masks[t]  = rows[t][MASK_W-1:0];
        assign routes[t] = rows[t][MASK_W +: N_SUM];
        assign divert[t] = rows[t][ROW_W-1];
    end
endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane
    import pla_pkg::*;
(
    input  logic [N_IN-1:0]               in_vec,
    input  logic [N_TERM-1:0][MASK_W-1:0] masks,
    output logic [N_TERM-1:0]             pterm
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_IN-1:0] want_hi;
        logic [N_IN-1:0] want_lo;
        assign want_hi  = masks[t][N_IN-1:0];
        assign want_lo  = masks[t][MASK_W-1:N_IN];
        assign pterm[t] = ~|(want_hi & ~in_vec) & ~|(want_lo & in_vec);
    end
endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane
    import pla_pkg::*;
(
    input  logic [N_TERM-1:0]            pterm,
    input  logic [N_TERM-1:0][N_SUM-1:0] routes,
    input  logic [N_TERM-1:0]            divert,
    output logic [N_SUM-1:0]             sums
);
    logic [N_TERM-1:0] live;
    assign live = pterm & ~divert;

    for (genvar m = 0; m < N_SUM; m++) begin : g_sum
        logic [N_TERM-1:0] column;
        always_comb begin
            for (int t = 0; t < N_TERM; t++)
                column[t] = routes[t][m];
        end
        assign sums[m] = |(column & live);
    end
endmodule

// File: rtl/pla_ctl_select.sv
`timescale 1ns/1ps
module pla_ctl_select
    import pla_pkg::*;
#(
    parameter int N_SLOT = 1
) (
    input  logic [N_SLOT-1:0][CTL_W-1:0] words,
    input  logic [N_TERM-1:0]            pterm,
    output logic [N_SLOT*N_KIND-1:0]     ctl
);
    localparam int PAD_W = 2 ** IDX_W;
    logic [PAD_W-1:0] padded;
    assign padded = PAD_W'(pterm);

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        for (genvar k = 0; k < N_KIND; k++) begin : g_kind
            logic [IDX_W-1:0] idx;
            logic             en;
            assign idx = words[s][k*FIELD_W +: IDX_W];
            assign en  = words[s][k*FIELD_W + IDX_W];
            assign ctl[s*N_KIND + k] = en & (idx < IDX_W'(N_TERM)) & padded[idx];
        end
    end
endmodule

// File: rtl/pla_slice.sv
`timescale 1ns/1ps
module pla_slice
    import pla_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_IN-1:0]           in_vec,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [ROW_W-1:0]          cfg_wdata,
    output logic [N_SUM-1:0]          sum_out,
    output logic [N_SUM*N_KIND-1:0]   mc_ctl,
    output logic [N_KIND-1:0]         blk_ctl
);
    logic [N_TERM-1:0][MASK_W-1:0] w_masks;
    logic [N_TERM-1:0][N_SUM-1:0]  w_routes;
    logic [N_TERM-1:0]             w_divert;
    logic [N_SUM-1:0][CTL_W-1:0]   w_mc_words;
    logic [CTL_W-1:0]              w_blk_word;
    logic [N_TERM-1:0]             w_pterm;

    pla_cfg_store u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .masks    (w_masks),
        .routes   (w_routes),
        .divert   (w_divert),
        .mc_words (w_mc_words),
        .blk_word (w_blk_word)
    );

    pla_and_plane u_and (
        .in_vec(in_vec),
        .masks (w_masks),
        .pterm (w_pterm)
    );

    pla_or_plane u_or (
        .pterm (w_pterm),
        .routes(w_routes),
        .divert(w_divert),
        .sums  (sum_out)
    );

    pla_ctl_select #(.N_SLOT(N_SUM)) u_mc_sel (
        .words(w_mc_words),
        .pterm(w_pterm),
        .ctl  (mc_ctl)
    );

    pla_ctl_select #(.N_SLOT(1)) u_blk_sel (
        .words(w_blk_word),
        .pterm(w_pterm),
        .ctl  (blk_ctl)
    );
endmodule

// File: rtl/pla_slice_chk.sv
`timescale 1ns/1ps
module pla_slice_chk
    import pla_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_we,
    input logic [N_IN-1:0]               in_vec,
    input logic [N_SUM-1:0]              sum_out,
    input logic [N_SUM*N_KIND-1:0]       mc_ctl,
    input logic [N_KIND-1:0]             blk_ctl,
    input logic [N_TERM-1:0][MASK_W-1:0] masks,
    input logic [N_TERM-1:0]             pterm,
    input logic [N_SUM-1:0][CTL_W-1:0]   mc_words,
    input logic [CTL_W-1:0]              blk_word
);
    AST_RESET_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_out == '0 && mc_ctl == '0 && blk_ctl == '0)); // R10

    AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && $stable(in_vec)) |->
            ($stable(sum_out) && $stable(mc_ctl) && $stable(blk_ctl))); // R9

    for (genvar t = 0; t < N_TERM; t++) begin : g_conf
        AST_CONFLICT_TERM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (|(masks[t][N_IN-1:0] & masks[t][MASK_W-1:N_IN])) |-> !pterm[t]); // R3
    end

    for (genvar s = 0; s < N_SUM; s++) begin : g_mc
        for (genvar k = 0; k < N_KIND; k++) begin : g_k
            AST_MC_CTL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
                !mc_words[s][k*FIELD_W + IDX_W] |-> !mc_ctl[s*N_KIND + k]); // R7
        end
    end

    for (genvar k = 0; k < N_KIND; k++) begin : g_blk
        AST_BLK_CTL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !blk_word[k*FIELD_W + IDX_W] |-> !blk_ctl[k]); // R8
    end
endmodule

bind pla_slice pla_slice_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .in_vec  (in_vec),
    .sum_out (sum_out),
    .mc_ctl  (mc_ctl),
    .blk_ctl (blk_ctl),
    .masks   (w_masks),
    .pterm   (w_pterm),
    .mc_words(w_mc_words),
    .blk_word(w_blk_word)
);

// File: tb/sim_pla_slice.sv
`timescale 1ns/1ps
module sim_pla_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] in_vec = '0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [96:0] cfg_wdata = '0;
    logic [15:0] sum_out;
    logic [63:0] mc_ctl;
    logic [3:0]  blk_ctl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pla_slice u0 (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .sum_out(sum_out), .mc_ctl(mc_ctl), .blk_ctl(blk_ctl)
    );

    // reference model of the configuration
    logic [79:0] m_mask  [56];
    logic [15:0] m_route [56];
    logic        m_div   [56];
    logic [27:0] m_ctl   [17];

    typedef struct {
        logic [15:0] s;
        logic [63:0] mc;
        logic [3:0]  blk;
        string       tag;
    } exp_t;
    exp_t sb[$];

    function automatic logic [55:0] model_terms(input logic [39:0] x);
        logic [55:0] p;
        for (int t = 0; t < 56; t++)
            p[t] = ((m_mask[t][39:0] & ~x) == '0) && ((m_mask[t][79:40] & x) == '0);
        return p;
    endfunction

    function automatic logic ctl_pick(input logic [27:0] w, input int k, input logic [55:0] p);
        int idx;
        idx = int'(w[k*7 +: 6]);
        if (!w[k*7+6] || idx >= 56) return 1'b0;
        return p[idx];
    endfunction

    function automatic void push(input string tag);
        exp_t e;
        logic [55:0] p;
        p = model_terms(in_vec);
        e.s = '0; e.mc = '0; e.blk = '0; e.tag = tag;
        for (int t = 0; t < 56; t++)
            if (p[t] && !m_div[t]) e.s |= m_route[t];
        for (int m = 0; m < 16; m++)
            for (int k = 0; k < 4; k++)
                e.mc[m*4+k] = ctl_pick(m_ctl[m], k, p);
        for (int k = 0; k < 4; k++)
            e.blk[k] = ctl_pick(m_ctl[16], k, p);
        sb.push_back(e);
    endfunction

    task automatic drive_vec(input logic [39:0] x, input string tag);
        @(posedge clk); #1;
        in_vec = x;
        push(tag);
    endtask

    task automatic cfg_write(input int a, input logic [96:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
        push("R9 old config until edge");
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (a < 56) {m_div[a], m_route[a], m_mask[a]} = d;
        else if (a < 72) m_ctl[a-56] = d[27:0];
        else if (a == 72) m_ctl[16] = d[27:0];
    endtask

    function automatic logic [96:0] row(input logic [39:0] hi, input logic [39:0] lo,
                                        input logic [15:0] rt, input logic dv);
        return {dv, rt, lo, hi};
    endfunction

    // monitor: pops one expected item per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (sum_out !== e.s || mc_ctl !== e.mc || blk_ctl !== e.blk) begin
                    failures++;
                    $display("FAIL %s: got sum=%h mc=%h blk=%h expected sum=%h mc=%h blk=%h",
                             e.tag, sum_out, mc_ctl, blk_ctl, e.s, e.mc, e.blk);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 56; t++) begin m_mask[t] = '0; m_route[t] = '0; m_div[t] = 1'b0; end
        for (int s = 0; s < 17; s++) m_ctl[s] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        drive_vec(40'h0, "R10 reset state");
        drive_vec(40'hFF_FFFF_FFFF, "R10 reset state all ones");

        // R1: in0 & ~in1 -> sum0
        cfg_write(0, row(40'h1, 40'h2, 16'h0001, 1'b0));
        // R2: empty term -> sum1
        cfg_write(1, row(40'h0, 40'h0, 16'h0002, 1'b0));
        // R3: conflict on in5 -> sum2
        cfg_write(2, row(40'h20, 40'h20, 16'h0004, 1'b0));
        // R5: in7 shared into sums 3 and 4
        cfg_write(3, row(40'h80, 40'h0, 16'h0018, 1'b0));
        // R6: in10 & in11 diverted, route to sum6 ignored
        cfg_write(4, row(40'hC00, 40'h0, 16'h0040, 1'b1));
        // R7: macrocell 2, kind1 -> term4, kind3 -> index 60 (out of range)
        cfg_write(58, 97'({1'b1, 6'd60, 7'd0, 1'b1, 6'd4, 7'd0}));
        // R8: block kind0 -> term0, kind3 -> term4
        cfg_write(72, 97'({1'b1, 6'd4, 14'd0, 1'b1, 6'd0}));

        drive_vec(40'h0, "R2 R5 empty term and unrouted sum");
        drive_vec(40'h1, "R1 true literal hit");
        drive_vec(40'h3, "R1 complement literal blocks");
        drive_vec(40'h20, "R3 conflicting literals");
        drive_vec(40'h80, "R5 shared term");
        drive_vec(40'hC00, "R6 R7 R8 diverted term as control");
        drive_vec(40'h400, "R7 R8 partial term");
        drive_vec(40'hC81, "R4 R6 R7 mixed");

        // R11: out-of-range write ignored
        cfg_write(100, {97{1'b1}});
        drive_vec(40'hC81, "R11 ignored write");
        drive_vec(40'h0, "R11 ignored write zero input");

        // R4: random full configuration and random inputs
        for (int t = 0; t < 56; t++) begin
            logic [79:0] mk;
            mk = '0;
            repeat ($urandom % 4) mk[$urandom % 80] = 1'b1;
            cfg_write(t, {1'b0, 16'($urandom), mk} | {($urandom % 8) == 0, 96'd0});
        end
        for (int s = 0; s <= 16; s++)
            cfg_write(56 + s, 97'($urandom));
        for (int n = 0; n < 300; n++)
            drive_vec({8'($urandom), 32'($urandom)}, "R4 random sum-of-products");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule